// File: doc/BRIEF.md
# ADC window-check test sequencer

This block drives a sample-and-hold comparator ADC front end through a fixed run of eleven configuration steps. The run decides whether an analog input lies inside a tolerance window around a nominal voltage. In every step the sequencer sets five controls: the converter enable, a 10-bit DAC threshold code, the input channel select, a hold line and a precharge line. The run takes two fresh samples of the input. It compares the first sample with a lower threshold and the second with an upper threshold. The comparator is read at the end of each precharge step.

A one-cycle start pulse launches a run while the block is idle. The busy flag stays high until the run ends. After that, done is set together with exactly one of pass or fail. Those outputs hold their values until the next accepted start. The block also has a hold watchdog, because a held sample on the capacitor decays. If hold stays high for more consecutive cycles than a programmable limit, the watchdog aborts the run. It then reports fail and sets a sticky timeout flag. The thresholds come from 1024 × Vin × (1 ∓ tolerance) / Vref. For 1.5 V ± 5 % against a 5.0 V reference they are 291 (0x123) and 323 (0x143), and both are parameters.

Top module: `adc_window_seq`

## Requirements
- R1: A start pulse while idle begins a run of 11 steps. Each step lasts step_len cycles, and a step_len of 0 counts as 1. busy is high for exactly 11 × that length cycles and then falls, and done rises in the same cycle.
- R2: While busy, adc_en is 1 and mux_sel is 0x08 (channel 3). dac_code is 0x123 in steps 4–5, 0x143 in steps 9–10 and 0x200 in every other step. hold is 0 only in steps 2 and 7. prech is 0 only in steps 5 and 10. Steps are numbered 1 to 11.
- R3: While idle, adc_en is 0, hold and prech are 1, dac_code is 0x200 and mux_sel is 0x08. pin_data, pin_dir and pin_pullup are 0 at all times.
- R4: The comparator is sampled on the last cycle of step 5, and the lower check passes only if it reads 0 there.
- R5: The comparator is sampled on the last cycle of step 10, and the upper check passes only if it reads 1 there. At completion, pass is 1 only if both checks passed, and fail equals the inverse of pass.
- R6: Suppose hold stays high while busy for more consecutive cycles than hold_limit. The run then aborts in the cycle in which the count would exceed the limit. busy falls, and done, fail and timeout become 1 while pass is 0. A run of exactly hold_limit cycles does not trip the watchdog.
- R7: done, pass, fail and timeout keep their values until the next accepted start, which clears them. A start pulse while busy is ignored.
- R8: After reset, busy, done, pass, fail and timeout are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a run when idle |
| step_len | input | 8 | Cycles per step, latched at start (0 acts as 1) |
| hold_limit | input | 12 | Maximum consecutive hold-high cycles, latched at start |
| cmp_in | input | 1 | Comparator output from the analog front end |
| adc_en | output | 1 | Converter enable |
| dac_code | output | 10 | DAC threshold code |
| mux_sel | output | 5 | Input multiplexer select |
| hold | output | 1 | Hold line, low to take a sample |
| prech | output | 1 | Precharge line, low to evaluate |
| pin_data | output | 1 | Channel pin data, tied 0 |
| pin_dir | output | 1 | Channel pin direction, tied 0 |
| pin_pullup | output | 1 | Channel pin pull-up enable, tied 0 |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (completed or aborted) |
| pass | output | 1 | Input inside the window |
| fail | output | 1 | Input outside the window, or aborted |
| timeout | output | 1 | Hold watchdog tripped during the last run |

## Verification
The bench models the comparator so that its output reads the opposite of the true comparison whenever precharge is high. A design that samples in the wrong step therefore reports the wrong verdict. Inputs sit exactly on each threshold code. A window that is off by one code, or a check whose polarity is inverted, passes the 323 case or fails the 291 case. Hold limits one below and exactly equal to the longest hold-high run show whether the watchdog compares with the right inclusive bound. An abort that fires in the wrong cycle shows up as a wrong busy length. A step length of zero, and a start issued mid-run, expose a counter that wraps and a run that restarts.

// File: rtl/adc_seq_pkg.sv
// Package: shared step configuration type and the fixed eleven-step table
// for the ADC window-check sequencer.
// Assumes: steps are indexed 0..10 (step n of the run is index n-1).
package adc_seq_pkg;

    localparam int unsigned NUM_STEPS = 11;
    localparam int unsigned IDX_W     = 4;
    localparam int unsigned LO_IDX    = 4;   // last step before lower verdict
    localparam int unsigned HI_IDX    = 9;   // last step before upper verdict
    localparam int unsigned LAST_IDX  = NUM_STEPS - 1;

    typedef enum logic [1:0] {
        LVL_REST = 2'd0,
        LVL_LO   = 2'd1,
        LVL_HI   = 2'd2
    } dac_level_e;

    typedef struct packed {
        logic       en;
        logic       hold;
        logic       prech;
        dac_level_e level;
    } step_cfg_t;

    localparam step_cfg_t IDLE_CFG = '{en: 1'b0, hold: 1'b1, prech: 1'b1, level: LVL_REST};

    // Returns the control pattern for one step index.
    function automatic step_cfg_t step_cfg(input logic [IDX_W-1:0] idx);
        step_cfg_t c;
        c = '{en: 1'b1, hold: 1'b1, prech: 1'b1, level: LVL_REST};
        case (idx)
            4'd1, 4'd6: c.hold  = 1'b0;
            4'd3:       c.level = LVL_LO;
            4'd4: begin c.level = LVL_LO; c.prech = 1'b0; end
            4'd8:       c.level = LVL_HI;
            4'd9: begin c.level = LVL_HI; c.prech = 1'b0; end
            4'd0, 4'd2, 4'd5, 4'd7, 4'd10: c = c;
            default:    c = IDLE_CFG;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
// Module: step sequencer. Holds the run state, the current step index and
// the cycle count inside the step.
// Assumes: step_len is latched at the accepted start; abort only arrives
// while busy and takes priority over normal advance.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned SLEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SLEN_W-1:0] step_len,
    input  logic             abort,
    output logic             go,
    output logic             busy,
    output logic [IDX_W-1:0] step_idx,
    output logic             step_last,
    output logic             seq_end
);

    logic [SLEN_W-1:0] cyc_q;
    logic [SLEN_W-1:0] last_cnt_q;

    // Start is accepted only while idle.
    assign go        = start && !busy;
    // Last cycle of the current step.
    assign step_last = busy && (cyc_q == last_cnt_q);
    // Last cycle of the final step.
    assign seq_end   = step_last && (step_idx == IDX_W'(LAST_IDX));

    // Run state, step index and in-step cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            step_idx   <= '0;
            cyc_q      <= '0;
            last_cnt_q <= '0;
        end else if (abort) begin
            busy <= 1'b0;
        end else if (go) begin
            busy       <= 1'b1;
            step_idx   <= '0;
            cyc_q      <= '0;
            last_cnt_q <= (step_len == '0) ? '0 : step_len - 1'b1;
        end else if (busy) begin
            if (step_last) begin
                cyc_q <= '0;
                if (seq_end) busy <= 1'b0;
                else         step_idx <= step_idx + 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (step_idx <= IDX_W'(LAST_IDX)));                       // R1
    AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cyc_q <= last_cnt_q));                                 // R1
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !abort && !step_last) |=> (busy && $stable(step_idx))); // R7

endmodule

// File: rtl/adc_seq_hold_wd.sv
// Module: hold watchdog. Counts consecutive busy cycles with hold high and
// flags an overrun in the cycle that would exceed the latched limit.
// Assumes: the sequencer aborts on overrun, so the count never passes the limit.
module adc_seq_hold_wd #(
    parameter int unsigned HOLD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              busy,
    input  logic              hold,
    input  logic [HOLD_W-1:0] hold_limit,
    output logic              overrun
);

    logic [HOLD_W-1:0] run_q;
    logic [HOLD_W-1:0] lim_q;

    // Overrun when this cycle would be one past the allowed run length.
    assign overrun = busy && hold && (run_q >= lim_q);

    // Latches the limit at start and counts earlier hold-high cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            lim_q <= '0;
        end else begin
            if (go) lim_q <= hold_limit;
            if (!busy || !hold) run_q <= '0;
            else                run_q <= run_q + 1'b1;
        end
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q <= lim_q));                                      // R6
    AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !hold) |=> (run_q == '0));                              // R6

endmodule

// File: rtl/adc_seq_verdict.sv
// Module: verdict logic. Captures the two comparator checks and holds the
// done/pass/fail/timeout status until the next accepted start.
// Assumes: step_last/step_idx come from the sequencer; abort and seq_end
// never coincide with go.
module adc_seq_verdict
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             step_last,
    input  logic [IDX_W-1:0] step_idx,
    input  logic             seq_end,
    input  logic             abort,
    input  logic             cmp_in,
    output logic             done,
    output logic             pass,
    output logic             fail,
    output logic             timeout
);

    logic lo_ok_q;
    logic hi_ok_q;

    // Captures the two window checks at the end of the precharge steps.
    always_ff @(posedge clk) begin
        if (!rst_n || go) begin
            lo_ok_q <= 1'b0;
            hi_ok_q <= 1'b0;
        end else if (step_last) begin
            if (step_idx == IDX_W'(LO_IDX)) lo_ok_q <= !cmp_in;
            if (step_idx == IDX_W'(HI_IDX)) hi_ok_q <= cmp_in;
        end
    end

    // Sticky status: cleared at start, set at completion or abort.
    always_ff @(posedge clk) begin
        if (!rst_n || go) begin
            done    <= 1'b0;
            pass    <= 1'b0;
            fail    <= 1'b0;
            timeout <= 1'b0;
        end else if (abort) begin
            done    <= 1'b1;
            pass    <= 1'b0;
            fail    <= 1'b1;
            timeout <= 1'b1;
        end else if (seq_end) begin
            done <= 1'b1;
            pass <= lo_ok_q && hi_ok_q;
            fail <= !(lo_ok_q && hi_ok_q);
        end
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass != fail));                                        // R5
    AST_TIMEOUT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (fail && !pass && done));                            // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !go) |=> (done && $stable(pass) && $stable(timeout)));  // R7

endmodule

// File: rtl/adc_window_seq.sv
// Module: top of the ADC window-check sequencer. Wires the step sequencer,
// hold watchdog and verdict logic, and decodes the step table onto the
// analog front-end controls.
// Assumes: cmp_in is settled on the last cycle of each precharge step.
module adc_window_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned SLEN_W   = 8,
    parameter int unsigned HOLD_W   = 12,
    parameter int unsigned DAC_W    = 10,
    parameter int unsigned MUX_W    = 5,
    parameter logic [DAC_W-1:0] DAC_REST = 10'h200,
    parameter logic [DAC_W-1:0] DAC_LO   = 10'h123,
    parameter logic [DAC_W-1:0] DAC_HI   = 10'h143,
    parameter logic [MUX_W-1:0] MUX_CH   = 5'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SLEN_W-1:0] step_len,
    input  logic [HOLD_W-1:0] hold_limit,
    input  logic              cmp_in,
    output logic              adc_en,
    output logic [DAC_W-1:0]  dac_code,
    output logic [MUX_W-1:0]  mux_sel,
    output logic              hold,
    output logic              prech,
    output logic              pin_data,
    output logic              pin_dir,
    output logic              pin_pullup,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic              timeout
);

    logic             go;
    logic [IDX_W-1:0] step_idx;
    logic             step_last;
    logic             seq_end;
    logic             overrun;
    step_cfg_t        cfg;

    adc_seq_ctrl #(.SLEN_W(SLEN_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .step_len  (step_len),
        .abort     (overrun),
        .go        (go),
        .busy      (busy),
        .step_idx  (step_idx),
        .step_last (step_last),
        .seq_end   (seq_end)
    );

    adc_seq_hold_wd #(.HOLD_W(HOLD_W)) u_wd (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .busy       (busy),
        .hold       (hold),
        .hold_limit (hold_limit),
        .overrun    (overrun)
    );

    adc_seq_verdict u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .step_last (step_last),
        .step_idx  (step_idx),
        .seq_end   (seq_end),
        .abort     (overrun),
        .cmp_in    (cmp_in),
        .done      (done),
        .pass      (pass),
        .fail      (fail),
        .timeout   (timeout)
    );

    // Selects the step pattern while running, the safe pattern while idle.
    always_comb begin
        cfg = busy ? step_cfg(step_idx) : IDLE_CFG;
    end

    // Maps the step pattern onto the front-end controls.
    always_comb begin
        adc_en  = cfg.en;
        hold    = cfg.hold;
        prech   = cfg.prech;
        mux_sel = MUX_CH;
        case (cfg.level)
            LVL_LO:  dac_code = DAC_LO;
            LVL_HI:  dac_code = DAC_HI;
            default: dac_code = DAC_REST;
        endcase
    end

    assign pin_data   = 1'b0;
    assign pin_dir    = 1'b0;
    assign pin_pullup = 1'b0;

    AST_IDLE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!adc_en && hold && prech));                           // R3
    AST_NO_SAMPLE_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (hold || prech));                                       // R2
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));                                                // R1
    AST_EVAL_ON_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !prech) |-> (dac_code != DAC_REST));                    // R2

endmodule

// File: tb/sim_adc_window_seq.sv
// Directed bench for adc_window_seq with a behavioural comparator model.
module sim_adc_window_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  step_len = 8'd3;
    logic [11:0] hold_limit = 12'd100;
    logic        cmp_in;
    logic        adc_en, hold, prech, pin_data, pin_dir, pin_pullup;
    logic [9:0]  dac_code;
    logic [4:0]  mux_sel;
    logic        busy, done, pass, fail, timeout;
    logic [9:0]  vin = 10'd300;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    // Comparator: 1 when input is below threshold; inverted garbage unless evaluating.
    always_comb cmp_in = !prech ? (vin < dac_code) : !(vin < dac_code);

    adc_window_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .step_len(step_len),
        .hold_limit(hold_limit), .cmp_in(cmp_in), .adc_en(adc_en),
        .dac_code(dac_code), .mux_sel(mux_sel), .hold(hold), .prech(prech),
        .pin_data(pin_data), .pin_dir(pin_dir), .pin_pullup(pin_pullup),
        .busy(busy), .done(done), .pass(pass), .fail(fail), .timeout(timeout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected pattern for step index s (0..10): {en,hold,prech,dac}.
    function automatic bit pattern_ok(input int s);
        logic [9:0] d;
        d = (s == 3 || s == 4) ? 10'h123 : (s == 8 || s == 9) ? 10'h143 : 10'h200;
        return adc_en && mux_sel == 5'h08 && dac_code == d &&
               hold == !(s == 1 || s == 6) && prech == !(s == 4 || s == 9) &&
               !pin_data && !pin_dir && !pin_pullup;
    endfunction

    // Runs one sequence; returns busy length and pattern mismatch count.
    task automatic run(input logic [9:0] v, input logic [7:0] len, input logic [11:0] lim,
                       input bit poke_start, output int cycles, output int bad);
        int leff;
        leff = (len == 0) ? 1 : len;
        vin = v; step_len = len; hold_limit = lim;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cycles = 0; bad = 0;
        while (busy && cycles < 5000) begin
            if (!pattern_ok(cycles / leff)) bad++;
            if (poke_start && cycles == 5) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
    endtask

    task automatic t_reset;
        check(!busy && !done && !pass && !fail && !timeout, "R8 reset status",
              {busy, done, pass, fail, timeout}, 0);
        check(!adc_en && hold && prech && dac_code == 10'h200 && mux_sel == 5'h08,
              "R3 idle controls", {adc_en, hold, prech}, 3);
    endtask

    task automatic t_pass;
        int c, b;
        run(10'd300, 8'd3, 12'd100, 1'b0, c, b);
        check(c == 33, "R1 busy length", c, 33);
        check(b == 0, "R2 step pattern", b, 0);
        check(done && pass && !fail && !timeout, "R5 pass inside window", {done, pass, fail}, 6);
        check(!adc_en && hold && prech && !pin_data && !pin_dir && !pin_pullup,
              "R3 idle after run", {adc_en, hold, prech}, 3);
        repeat (4) @(negedge clk);
        check(done && pass, "R7 status held", {done, pass}, 3);
    endtask

    task automatic t_window(input logic [9:0] v, input bit exp_pass, input string req);
        int c, b;
        run(v, 8'd2, 12'd100, 1'b0, c, b);
        check(done && pass == exp_pass && fail == !exp_pass && !timeout, req, {pass, fail}, {exp_pass, !exp_pass});
    endtask

    task automatic t_zero_len;
        int c, b;
        run(10'd300, 8'd0, 12'd100, 1'b0, c, b);
        check(c == 11 && b == 0, "R1 zero step length", c, 11);
        check(pass, "R5 pass at length one", pass, 1);
    endtask

    task automatic t_timeout;
        int c, b;
        run(10'd300, 8'd3, 12'd11, 1'b0, c, b);   // longest run 12 > 11
        check(c == 18, "R6 abort cycle", c, 18);
        check(done && fail && !pass && timeout, "R6 abort status", {done, pass, fail, timeout}, 11);
        check(!adc_en && hold, "R3 idle after abort", adc_en, 0);
        run(10'd300, 8'd3, 12'd12, 1'b0, c, b);   // exactly at the limit
        check(c == 33 && pass && !timeout, "R6 limit inclusive", c, 33);
    endtask

    task automatic t_restart;
        int c, b;
        run(10'd300, 8'd3, 12'd11, 1'b0, c, b);
        check(timeout, "R6 timeout before restart", timeout, 1);
        @(negedge clk) start = 1'b1; hold_limit = 12'd100;
        @(negedge clk) start = 1'b0;
        check(busy && !done && !timeout && !fail && !pass, "R7 start clears status",
              {busy, done, timeout}, 4);
        while (busy) @(negedge clk);
        run(10'd300, 8'd3, 12'd100, 1'b1, c, b);
        check(c == 33 && b == 0 && pass, "R7 start ignored while busy", c, 33);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_window(10'd280, 1'b0, "R4 below lower threshold");
        t_window(10'd291, 1'b1, "R4 on lower threshold");
        t_window(10'd323, 1'b0, "R5 on upper threshold");
        t_window(10'd322, 1'b1, "R5 just below upper threshold");
        t_window(10'd340, 1'b0, "R5 above upper threshold");
        t_zero_len();
        t_timeout();
        t_restart();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule